// File: doc/BRIEF.md
# Repeated-Subtraction Serial Divider

This block divides one unsigned operand by another over several clock cycles. A request carries a dividend and a divisor. The block loads the dividend into a running-remainder register and latches the divisor. On each following clock it subtracts the divisor once and counts that subtraction, until the running value is smaller than the divisor. The count is then the quotient, and the value left in the register is the remainder.

The subtraction uses one's complement arithmetic. A ripple chain adds the running remainder to the inverted divisor. The chain's carry-out decides whether the step is kept:

- **Carry set:** the end-around carry is folded back in and the result is kept.
- **All-ones sum with no carry:** this is a negative zero, which means the two operands were equal. The step is kept and the result is zero.
- **Anything else:** the running value is smaller than the divisor, and the division ends.

**Request handshake.** The request side is a valid/ready handshake. `in_ready` is high only while no division is in progress. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a division runs, `in_ready` stays low and the request is held off: the operands on the inputs have no effect, and the source keeps them until it is accepted.

**Result side.** The result side has no back-pressure. `done` is a single-cycle pulse. `quotient`, `remainder` and `div_zero` then hold their values until the next request is accepted.

Top module: `rsd_divider`

## Requirements
- R1: When `done` pulses with `div_zero` low, `quotient` equals the integer floor of dividend/divisor and `remainder` equals dividend modulo divisor. Both operands are taken at the accepting edge. Example: 13 over 3 gives 4 and 1.
- R2: While running, the running values are visible on the outputs. Each clock, `quotient` rises by one and `remainder` drops by the divisor, as long as the running remainder is at least the divisor.
- R3: A running remainder equal to the divisor counts as one more subtraction. Examples: 3 over 3 gives quotient 1 and remainder 0; 15 over 15 gives 1 and 0.
- R4: For a non-zero divisor, `done` is high in the cycle after edge number q+1 counted from the accepting edge, where q is the quotient. Dividend 15 with divisor 1 therefore takes 16 edges.
- R5: A divisor of zero ends the request at once. `done` and `div_zero` are high right after the accepting edge, `quotient` is 0 and `remainder` equals the dividend.
- R6: `in_ready` is low from the accepting edge of a non-zero-divisor request until `done`. A request presented in that window is ignored and does not change the result.
- R7: `done` lasts exactly one cycle. `quotient`, `remainder` and `div_zero` then stay unchanged until the next accepted request.
- R8: Synchronous reset `rst` clears `quotient`, `remainder`, `done` and `div_zero`, and leaves `in_ready` high. This includes a reset in the middle of a division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| dividend | input | W (4) | Unsigned dividend |
| divisor | input | W (4) | Unsigned divisor |
| quotient | output | W (4) | Subtraction count, the final quotient at `done` |
| remainder | output | W (4) | Running remainder, the final remainder at `done` |
| done | output | 1 | One-cycle pulse, result valid |
| div_zero | output | 1 | Last request had a zero divisor |

## Verification
Every output is registered. A request taken on edge 0 therefore shows its first effect just after that edge. The running quotient and remainder move once per later edge, and `done` appears just after edge q+1, or just after edge 0 for a zero divisor. The bench advances a behavioural model in step with each edge and compares every output about a quarter period after that edge. It counts edges from the accepting edge on its own, so the moment `done` appears is checked against the quotient computed with integer division.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rsd_state_e;
endpackage

// File: rtl/rsd_ocsub.sv
// One's complement subtractor: minuend + ~subtrahend on a ripple chain,
// end-around carry folded back by a second ripple increment.
module rsd_ocsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         fits
);
  logic [W-1:0] inv_b;
  logic [W-1:0] raw_sum;
  logic [W:0]   cy;
  logic [W-1:0] inc_cy;
  logic [W-1:0] folded;
  logic         neg_zero;

  assign inv_b = ~subtrahend;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign raw_sum[i] = minuend[i] ^ inv_b[i] ^ cy[i];
    assign cy[i+1]    = (minuend[i] & inv_b[i]) | (cy[i] & (minuend[i] ^ inv_b[i]));
  end

  assign inc_cy[0] = cy[W];
  for (genvar i = 0; i < W; i++) begin : g_inc
    assign folded[i] = raw_sum[i] ^ inc_cy[i];
    if (i < W - 1) begin : g_nxt
      assign inc_cy[i+1] = raw_sum[i] & inc_cy[i];
    end
  end

  assign neg_zero = (&raw_sum) & ~cy[W];
  assign fits     = cy[W] | neg_zero;
  assign diff     = cy[W] ? folded : '0;

  always_comb begin
    // R3
    sub_fits_chk: assert (fits == (minuend >= subtrahend));
    // R2
    if (fits) begin
      sub_exact_chk: assert (diff == W'(minuend - subtrahend));
    end
  end
endmodule

// File: rtl/rsd_remreg.sv
// Remainder register with load/feedback multiplexer, plus divisor latch.
module rsd_remreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] load_dvs,
  input  logic [W-1:0] diff,
  output logic [W-1:0] rem_q,
  output logic [W-1:0] dvs_q
);
  logic [W-1:0] rem_d;

  assign rem_d = load ? load_val : diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvs_q <= '0;
    end else begin
      if (load || step) rem_q <= rem_d;
      if (load)         dvs_q <= load_dvs;
    end
  end

  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(rem_q));

  // R6
  dvs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dvs_q));
endmodule

// File: rtl/rsd_count.sv
// Synchronous up counter holding the subtraction count.
module rsd_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (inc)     count <= count + ONE;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clear) |=> count == $past(count) + ONE);

  // R1
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> count != '1);
endmodule

// File: rtl/rsd_ctrl.sv
// Two-state sequencer: accepts requests, runs steps, flags completion.
module rsd_ctrl
  import rsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic divisor_zero,
  input  logic fits,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic done,
  output logic dz
);
  rsd_state_e state;
  logic       finish;

  assign in_ready = (state == ST_IDLE);
  assign load     = in_valid & in_ready;
  assign step     = (state == ST_RUN) & fits;
  assign finish   = (state == ST_RUN) & ~fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      dz    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        dz <= divisor_zero;
        if (divisor_zero) done  <= 1'b1;
        else              state <= ST_RUN;
      end else if (finish) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end
    end
  end

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (load && divisor_zero) |=> (done && dz && in_ready));

  // R4
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> (done && in_ready && !dz));

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !divisor_zero) |=> !in_ready);

  // R7
  dz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dz));
endmodule

// File: rtl/rsd_divider.sv
module rsd_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         div_zero
);
  logic [W-1:0] rem_q;
  logic [W-1:0] dvs_q;
  logic [W-1:0] diff;
  logic         fits;
  logic         load;
  logic         step;
  logic         divisor_zero;

  assign divisor_zero = (divisor == '0);

  rsd_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .divisor_zero(divisor_zero),
    .fits        (fits),
    .in_ready    (in_ready),
    .load        (load),
    .step        (step),
    .done        (done),
    .dz          (div_zero)
  );

  rsd_ocsub #(.W(W)) u_sub (
    .minuend   (rem_q),
    .subtrahend(dvs_q),
    .diff      (diff),
    .fits      (fits)
  );

  rsd_remreg #(.W(W)) u_rem (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .load_val(dividend),
    .load_dvs(divisor),
    .diff    (diff),
    .rem_q   (rem_q),
    .dvs_q   (dvs_q)
  );

  rsd_count #(.W(W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clear(load),
    .inc  (step),
    .count(quotient)
  );

  assign remainder = rem_q;

  // R1
  final_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero) |-> remainder < dvs_q);

  // R5
  dz_quot_chk: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> quotient == '0);
endmodule

// File: tb/sim_rsd_divider.sv
module sim_rsd_divider;
  localparam int W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         in_ready;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         done;
  logic         div_zero;

  rsd_divider #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .quotient(quotient),
    .remainder(remainder), .done(done), .div_zero(div_zero)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  // behavioural model state
  int m_busy = 0, m_rem = 0, m_q = 0, m_dvs = 0, m_done = 0, m_dz = 0;
  int m_a = 0, m_b = 0, lat = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    int nb = m_busy, nr = m_rem, nq = m_q, nd = m_dvs, ndz = m_dz, ndn = 0;
    if (rst) begin
      nb = 0; nr = 0; nq = 0; nd = 0; ndz = 0; ndn = 0;
    end else if (!m_busy && in_valid) begin
      m_a = int'(dividend); m_b = int'(divisor);
      lat = 0;
      nr = m_a; nq = 0; nd = m_b;
      if (m_b == 0) begin ndn = 1; ndz = 1; end
      else begin nb = 1; ndz = 0; end
    end else begin
      lat++;
      if (m_busy) begin
        if (m_rem >= m_dvs) begin nr = m_rem - m_dvs; nq = m_q + 1; end
        else begin nb = 0; ndn = 1; end
      end
    end
    @(posedge clk);
    #2;
    m_busy = nb; m_rem = nr; m_q = nq; m_dvs = nd; m_dz = ndz; m_done = ndn;
    chk(in_ready == (m_busy == 0), "R6 in_ready", int'(in_ready), int'(m_busy == 0));
    chk(int'(quotient) == m_q, "R2 quotient", int'(quotient), m_q);
    chk(int'(remainder) == m_rem, "R2 remainder", int'(remainder), m_rem);
    chk(int'(done) == m_done, "R4 done", int'(done), m_done);
    chk(int'(div_zero) == m_dz, "R5 div_zero", int'(div_zero), m_dz);
    if (done && !div_zero && !rst && m_b != 0) begin
      chk(int'(quotient) == m_a / m_b, "R1 quotient", int'(quotient), m_a / m_b);
      chk(int'(remainder) == m_a % m_b, "R1 remainder", int'(remainder), m_a % m_b);
      chk(lat == m_a / m_b + 1, "R4 latency", lat, m_a / m_b + 1);
    end
    if (done && div_zero && !rst) begin
      chk(lat == 0, "R5 latency", lat, 0);
      chk(int'(remainder) == m_a, "R5 remainder", int'(remainder), m_a);
      chk(quotient == '0, "R5 quotient", int'(quotient), 0);
    end
  endtask

  task automatic run(input int a, input int b);
    dividend = W'(a);
    divisor  = W'(b);
    in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    for (int k = 0; k < 40 && m_busy != 0; k++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hq, hr;
    rst = 1'b1;
    repeat (3) tick();
    // R8
    chk(quotient == '0 && remainder == '0, "R8 reset outputs", int'(quotient), 0);
    chk(!done && !div_zero && in_ready, "R8 reset flags", int'(done), 0);
    rst = 1'b0;
    tick();

    run(13, 3);
    chk(quotient == 4'd4 && remainder == 4'd1, "R1 13/3", int'(quotient), 4);

    run(15, 1);
    chk(quotient == 4'd15 && remainder == 4'd0, "R4 worst case", int'(quotient), 15);

    run(3, 3);
    chk(quotient == 4'd1 && remainder == 4'd0, "R3 equal 3/3", int'(quotient), 1);
    run(15, 15);
    chk(quotient == 4'd1 && remainder == 4'd0, "R3 equal 15/15", int'(quotient), 1);

    run(9, 0);
    chk(div_zero && quotient == '0 && remainder == 4'd9, "R5 9/0", int'(remainder), 9);

    // R7: results held while idle
    run(14, 4);
    hq = quotient; hr = remainder;
    repeat (4) tick();
    chk(quotient == hq && remainder == hr && !done, "R7 hold", int'(remainder), int'(hr));

    // R6: request offered while running is ignored
    dividend = 4'd15; divisor = 4'd1; in_valid = 1'b1;
    tick();
    dividend = 4'd9; divisor = 4'd2;
    repeat (3) tick();
    in_valid = 1'b0;
    for (int k = 0; k < 40 && m_busy != 0; k++) tick();
    chk(quotient == 4'd15 && remainder == 4'd0, "R6 ignored request", int'(quotient), 15);

    // R8: reset in the middle of a division
    dividend = 4'd12; divisor = 4'd1; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    repeat (4) tick();
    rst = 1'b1;
    tick();
    chk(quotient == '0 && remainder == '0 && in_ready && !done, "R8 mid-run reset",
        int'(quotient), 0);
    rst = 1'b0;
    tick();

    // back-to-back zero divisors: done on consecutive cycles
    run(5, 0);
    run(6, 0);
    chk(done && div_zero && remainder == 4'd6, "R5 back-to-back", int'(remainder), 6);

    // exhaustive sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(a, b);
      end
    end
    repeat (2) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule